// File: doc/BRIEF.md
# Single-Accumulator Instruction Core

This block is a 32-bit processor core whose only programmer-visible state is an accumulator, a program counter, and two condition flags: carry and overflow. Every instruction is one full word. It holds a 4-bit operation code in bits 31..28 and a 24-bit operand address in bits 23..0. Bits 27..24 carry no meaning.

The core runs a fixed loop. It fetches the word addressed by the program counter and decodes it. Then, depending on the operation, it reads one operand, writes the accumulator, or issues no bus cycle at all. All memory traffic goes through a simple request/acknowledge port to an external bus-cycle controller. A request is raised and held until the controller pulses the acknowledge for one cycle. Read data must be valid in that same cycle.

The sequencer has four states:
- `ST_FETCH`: read at the program counter.
- `ST_DECODE`: a single cycle that applies jumps and the shift.
- `ST_EXEC_RD`: operand read.
- `ST_EXEC_WR`: accumulator write.

The transitions are:
- fetch-ack: `ST_FETCH` to `ST_DECODE`.
- decode-read: `ST_DECODE` to `ST_EXEC_RD`, for opcodes 0, 2, 4, 5, 6 and 8.
- decode-write: `ST_DECODE` to `ST_EXEC_WR`, for opcode A.
- decode-done: `ST_DECODE` to `ST_FETCH`, for all other opcodes.
- exec-ack: `ST_EXEC_RD` or `ST_EXEC_WR` to `ST_FETCH`.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is low, the program counter, accumulator, carry and overflow are zero. The first request after reset is a read at address 0.
- R2: A fetch reads at the program counter and adds one to the counter. The opcode is taken from bits 31..28 and the address from bits 23..0. Bits 27..24 have no effect.
- R3: Opcodes 0, 2, 4, 5, 6 and 8 issue exactly one read at the address field. Opcode A issues one write of the accumulator to the address field and leaves the accumulator unchanged. All other opcodes issue no execute cycle.
- R4: Opcode 0 adds the operand to the accumulator. Carry is set to the unsigned carry-out of bit 31. Overflow is set on two's-complement overflow.
- R5: Opcode 2 subtracts the operand from the accumulator. Carry is set when the unsigned result is negative, that is, on a borrow. Overflow is set on two's-complement overflow.
- R6: Opcodes 4, 5 and 6 store the bitwise OR, XOR and AND of the accumulator and the operand. Carry and overflow change only on opcodes 0 and 2.
- R7: Opcode 7 shifts the accumulator right by one bit and keeps bit 31. It uses no operand.
- R8: Opcode 8 copies the operand into the accumulator.
- R9: Opcode C always loads the program counter from the address field. Opcode D does so only when the accumulator is non-zero.
- R10: Opcode E jumps only when carry is clear. Opcode F jumps only when overflow is clear.
- R11: Opcodes 1, 3, 9 and B change no state other than the fetch increment.
- R12: Once raised, a request keeps its address and direction unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | output | 1 | A bus request is pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 24 | Word address of the request |
| req_wdata | output | 32 | Write data (the accumulator) |
| req_ack | input | 1 | One-cycle completion pulse from the bus-cycle controller |
| rd_data | input | 32 | Read data, valid while req_ack is high |

## Verification
The assertions assume that the controller raises `req_ack` only while `req_valid` is high, and for a single cycle per request. They also assume that `rd_data` is valid in the acknowledge cycle. The bench memory model follows these rules. It acknowledges only a pending request and drops the acknowledge on the next cycle. It varies the wait from zero to two cycles, so that a request must be held across several edges. The programs keep every address inside a 64-word memory image, so no request ever falls outside the model.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC_RD,
        ST_EXEC_WR
    } cpu_state_t;

    localparam logic [OPC_W-1:0] OP_ADD = 4'h0;
    localparam logic [OPC_W-1:0] OP_SUB = 4'h2;
    localparam logic [OPC_W-1:0] OP_IOR = 4'h4;
    localparam logic [OPC_W-1:0] OP_XOR = 4'h5;
    localparam logic [OPC_W-1:0] OP_AND = 4'h6;
    localparam logic [OPC_W-1:0] OP_ASR = 4'h7;
    localparam logic [OPC_W-1:0] OP_LOD = 4'h8;
    localparam logic [OPC_W-1:0] OP_STO = 4'hA;
    localparam logic [OPC_W-1:0] OP_JMP = 4'hC;
    localparam logic [OPC_W-1:0] OP_JNZ = 4'hD;
    localparam logic [OPC_W-1:0] OP_JNC = 4'hE;
    localparam logic [OPC_W-1:0] OP_JNV = 4'hF;

    // Operations that fetch a memory operand in the execute phase
    function automatic logic op_reads(input logic [OPC_W-1:0] op);
        case (op)
            OP_ADD, OP_SUB, OP_IOR, OP_XOR, OP_AND, OP_LOD: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Operations that update carry and overflow
    function automatic logic op_arith(input logic [OPC_W-1:0] op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OPC_W-1:0]  op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              cf,
    output logic              ov
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;

    always_comb begin
        wide = '0;
        y    = a;
        cf   = 1'b0;
        ov   = 1'b0;
        case (op)
            OP_ADD: begin
                wide = {1'b0, a} + {1'b0, b};
                y    = wide[MSB:0];
                cf   = wide[DATA_W];
                ov   = (a[MSB] == b[MSB]) && (y[MSB] != a[MSB]);
            end
            OP_SUB: begin
                wide = {1'b0, a} - {1'b0, b};
                y    = wide[MSB:0];
                cf   = wide[DATA_W];
                ov   = (a[MSB] != b[MSB]) && (y[MSB] != a[MSB]);
            end
            OP_IOR:  y = a | b;
            OP_XOR:  y = a ^ b;
            OP_AND:  y = a & b;
            OP_ASR:  y = {a[MSB], a[MSB:1]};
            OP_LOD:  y = b;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic [OPC_W-1:0] op,
    output cpu_state_t       state,
    output logic             req_valid,
    output logic             req_write,
    output logic             use_insn_addr
);
    cpu_state_t state_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FETCH:   if (ack) state_nxt = ST_DECODE;
            ST_DECODE: begin
                if (op_reads(op))       state_nxt = ST_EXEC_RD;
                else if (op == OP_STO)  state_nxt = ST_EXEC_WR;
                else                    state_nxt = ST_FETCH;
            end
            ST_EXEC_RD: if (ack) state_nxt = ST_FETCH;
            ST_EXEC_WR: if (ack) state_nxt = ST_FETCH;
        endcase
    end

    // Bus request outputs
    always_comb begin
        req_valid     = 1'b0;
        req_write     = 1'b0;
        use_insn_addr = 1'b0;
        unique case (state)
            ST_FETCH:   req_valid = 1'b1;
            ST_DECODE:  use_insn_addr = 1'b1;
            ST_EXEC_RD: begin
                req_valid     = 1'b1;
                use_insn_addr = 1'b1;
            end
            ST_EXEC_WR: begin
                req_valid     = 1'b1;
                req_write     = 1'b1;
                use_insn_addr = 1'b1;
            end
        endcase
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ack) |=> (req_valid && $stable(req_write) && $stable(use_insn_addr))); // R12

    AST_DECODE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE) |=> (state != ST_DECODE)); // R3

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              req_ack,
    input  logic [DATA_W-1:0] rd_data
);
    localparam int OPC_LSB = DATA_W - OPC_W;

    cpu_state_t        state;
    logic              use_insn_addr;
    logic [ADDR_W-1:0] pc_q;
    logic [OPC_W-1:0]  op_q;
    logic [ADDR_W-1:0] adr_q;
    logic [DATA_W-1:0] acc_q;
    logic              cf_q, ov_q;
    logic [DATA_W-1:0] alu_y;
    logic              alu_cf, alu_ov;
    logic              fetch_done, exec_done, in_decode, take_jump;

    acc_cpu_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .ack           (req_ack),
        .op            (op_q),
        .state         (state),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .use_insn_addr (use_insn_addr)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op (op_q),
        .a  (acc_q),
        .b  (rd_data),
        .y  (alu_y),
        .cf (alu_cf),
        .ov (alu_ov)
    );

    assign fetch_done = (state == ST_FETCH)   && req_ack;
    assign exec_done  = (state == ST_EXEC_RD) && req_ack;
    assign in_decode  = (state == ST_DECODE);

    always_comb begin
        case (op_q)
            OP_JMP:  take_jump = 1'b1;
            OP_JNZ:  take_jump = (acc_q != '0);
            OP_JNC:  take_jump = !cf_q;
            OP_JNV:  take_jump = !ov_q;
            default: take_jump = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            op_q  <= '0;
            adr_q <= '0;
            acc_q <= '0;
            cf_q  <= 1'b0;
            ov_q  <= 1'b0;
        end else begin
            if (fetch_done) begin
                op_q  <= rd_data[DATA_W-1:OPC_LSB];
                adr_q <= rd_data[ADDR_W-1:0];
                pc_q  <= pc_q + 1'b1;
            end
            if (in_decode && take_jump) pc_q <= adr_q;
            if (in_decode && (op_q == OP_ASR)) acc_q <= alu_y;
            if (exec_done) begin
                acc_q <= alu_y;
                if (op_arith(op_q)) begin
                    cf_q <= alu_cf;
                    ov_q <= alu_ov;
                end
            end
        end
    end

    assign req_addr  = use_insn_addr ? adr_q : pc_q;
    assign req_wdata = acc_q;

    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> (pc_q == $past(pc_q) + 1'b1)); // R2

    AST_ACC_KEEP_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC_WR) |=> $stable(acc_q)); // R3

    AST_FLAGS_ONLY_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_done && op_arith(op_q)) |=> $stable({cf_q, ov_q})); // R6

    AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_decode && (op_q == OP_JMP)) |=> (pc_q == $past(adr_q))); // R9

endmodule

// File: tb/acc_cpu_core_tb_top.sv
`timescale 1ns/1ps
module acc_cpu_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid, req_write;
    logic [23:0] req_addr;
    logic [31:0] req_wdata;
    logic        req_ack = 1'b0;
    logic [31:0] rd_data = '0;

    always #2.5 clk = ~clk;

    acc_cpu_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ack   (req_ack),
        .rd_data   (rd_data)
    );

    typedef struct {
        logic        wr;
        logic [23:0] addr;
        logic [31:0] data;
        string       tag;
    } item_t;

    item_t       exp_q[$];
    logic [31:0] img [0:63];
    logic [31:0] mem [0:63];
    int          checks = 0;
    int          errors = 0;
    bit          run_en = 1'b0;
    bit          finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ins(input logic [3:0] op, input logic [23:0] a);
        return {op, 4'h0, a};
    endfunction

    // Driver: instruction-level model pushes every expected bus transaction
    task automatic build_expect(input int n_instr);
        logic [31:0] m [0:63];
        logic [23:0] pc = '0;
        logic [31:0] acc = '0;
        logic [32:0] w;
        logic        c = 1'b0, v = 1'b0;
        string       nxt = "R1";
        string       last = "R8";
        for (int k = 0; k < 64; k++) m[k] = img[k];
        for (int i = 0; i < n_instr; i++) begin
            logic [31:0] word, b;
            logic [3:0]  op;
            logic [23:0] a;
            exp_q.push_back('{1'b0, pc, 32'h0, nxt});
            word = m[pc[5:0]];
            op = word[31:28];
            a  = word[23:0];
            b  = m[a[5:0]];
            pc = pc + 1;
            nxt = "R2";
            case (op)
                4'h0, 4'h2, 4'h4, 4'h5, 4'h6, 4'h8:
                    exp_q.push_back('{1'b0, a, 32'h0, "R3"});
                default: ;
            endcase
            case (op)
                4'h0: begin
                    w = {1'b0, acc} + {1'b0, b};
                    v = (acc[31] == b[31]) && (w[31] != acc[31]);
                    c = w[32]; acc = w[31:0]; last = "R4";
                end
                4'h2: begin
                    w = {1'b0, acc} - {1'b0, b};
                    v = (acc[31] != b[31]) && (w[31] != acc[31]);
                    c = (acc < b); acc = w[31:0]; last = "R5";
                end
                4'h4: begin acc = acc | b; last = "R6"; end
                4'h5: begin acc = acc ^ b; last = "R6"; end
                4'h6: begin acc = acc & b; last = "R6"; end
                4'h7: begin acc = {acc[31], acc[31:1]}; last = "R7"; end
                4'h8: begin acc = b; last = "R8"; end
                4'hA: begin
                    exp_q.push_back('{1'b1, a, acc, last});
                    m[a[5:0]] = acc;
                end
                4'hC: begin pc = a; nxt = "R9"; end
                4'hD: begin if (acc != 0) pc = a; nxt = "R9"; end
                4'hE: begin if (!c) pc = a; nxt = "R10"; end
                4'hF: begin if (!v) pc = a; nxt = "R10"; end
                default: nxt = "R11";
            endcase
        end
    endtask

    // Memory model and scoreboard monitor
    int          lat = 0, wait_cnt = 0, lat_sel = 0;
    bit          waiting = 1'b0, stable_ok = 1'b1;
    logic [23:0] hold_addr;
    logic        hold_wr;

    always @(negedge clk) begin
        if (!run_en) begin
            req_ack = 1'b0;
            waiting = 1'b0;
        end else if (req_ack) begin
            req_ack = 1'b0;
        end else if (req_valid && exp_q.size() > 0) begin
            if (!waiting) begin
                waiting   = 1'b1;
                stable_ok = 1'b1;
                hold_addr = req_addr;
                hold_wr   = req_write;
                wait_cnt  = 0;
                lat       = lat_sel % 3;
                lat_sel++;
            end else if (req_addr != hold_addr || req_write != hold_wr) begin
                stable_ok = 1'b0;
            end
            if (wait_cnt >= lat) begin
                item_t e;
                e = exp_q.pop_front();
                check(stable_ok, "R12", "request stable", {8'h0, req_addr}, {8'h0, hold_addr});
                check(req_write == e.wr, e.tag, "direction", {31'h0, req_write}, {31'h0, e.wr});
                check(req_addr == e.addr, e.tag, "address", {8'h0, req_addr}, {8'h0, e.addr});
                if (req_write) begin
                    check(req_wdata == e.data, e.tag, "store data", req_wdata, e.data);
                    mem[req_addr[5:0]] = req_wdata;
                end else begin
                    rd_data = mem[req_addr[5:0]];
                end
                req_ack = 1'b1;
                waiting = 1'b0;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic run_prog(input int n_instr);
        rst_n = 1'b0;
        run_en = 1'b0;
        for (int k = 0; k < 64; k++) mem[k] = img[k];
        exp_q.delete();
        build_expect(n_instr);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state shows as a read request at address 0
        check(req_valid == 1'b1 && req_write == 1'b0, "R1", "reset request",
              {30'h0, req_valid, req_write}, 32'h2);
        check(req_addr == 24'h0, "R1", "reset address", {8'h0, req_addr}, 32'h0);
        rst_n = 1'b1;
        run_en = 1'b1;
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        run_en = 1'b0;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        // Program A: add/sub flags, conditional jumps, shift, undefined opcodes
        for (int k = 0; k < 64; k++) img[k] = 32'h0;
        img[0]  = ins(4'h8, 24'd40);
        img[1]  = ins(4'h0, 24'd41);
        img[2]  = ins(4'hE, 24'd20);
        img[3]  = ins(4'hA, 24'd50);
        img[4]  = ins(4'h8, 24'd42);
        img[5]  = ins(4'h0, 24'd41);
        img[6]  = ins(4'hF, 24'd20);
        img[7]  = ins(4'hE, 24'd9);
        img[8]  = ins(4'h1, 24'd60);
        img[9]  = ins(4'h2, 24'd43);
        img[10] = ins(4'hA, 24'd51);
        img[11] = ins(4'h8, 24'd43);
        img[12] = ins(4'h2, 24'd44);
        img[13] = ins(4'hA, 24'd52);
        img[14] = ins(4'h7, 24'd0);
        img[15] = ins(4'hF, 24'd17);
        img[16] = ins(4'h3, 24'd61);
        img[17] = ins(4'hA, 24'd53);
        img[18] = ins(4'hC, 24'd18);
        img[20] = ins(4'hA, 24'd62);
        img[40] = 32'hFFFF_FFFF;
        img[41] = 32'h0000_0001;
        img[42] = 32'h7FFF_FFFF;
        img[43] = 32'h0000_0005;
        img[44] = 32'h0000_0007;
        run_prog(20);

        // Program B: logic ops, non-zero branch, spare bits, more undefined opcodes
        for (int k = 0; k < 64; k++) img[k] = 32'h0;
        img[0]  = ins(4'h8, 24'd45);
        img[1]  = ins(4'h4, 24'd46);
        img[2]  = ins(4'hA, 24'd54);
        img[3]  = ins(4'h5, 24'd47);
        img[4]  = ins(4'h6, 24'd48);
        img[5]  = ins(4'hA, 24'd55);
        img[6]  = ins(4'h9, 24'd58);
        img[7]  = ins(4'hB, 24'd59);
        img[8]  = ins(4'h1, 24'd60);
        img[9]  = ins(4'h7, 24'd0);
        img[10] = ins(4'hA, 24'd56);
        img[11] = ins(4'hD, 24'd13);
        img[12] = ins(4'hC, 24'd12);
        img[13] = 32'h8F00_0031;            // load from 49 with spare bits set (R2)
        img[14] = ins(4'hD, 24'd11);
        img[15] = ins(4'hA, 24'd57);
        img[16] = ins(4'hC, 24'd16);
        img[45] = 32'hF0F0_1234;
        img[46] = 32'h0F00_0001;
        img[47] = 32'hFFFF_0000;
        img[48] = 32'h00FF_FF0F;
        img[49] = 32'h0000_0000;
        run_prog(20);

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired, pending=%0d expected=0", exp_q.size());
        finish_run();
    end

endmodule